// File: doc/BRIEF.md
# Frequency-Trimmed Precision Time Counter

This block keeps a 64-bit time-of-day count for a precision time protocol stack. Each unit of the count stands for 32 ns, so software turns it into nanoseconds by shifting left by five places. The count does not simply follow the clock. Every cycle a programmable 32-bit rate word is added into a 32-bit fractional accumulator, and each carry out of that accumulator advances the count by one. Software tunes the frequency by nudging the rate word away from its nominal value 0xA0000000 by rate*ppb/1e9.

Around the counter there are three more functions. A 64-bit alarm comparator raises an event once the count reaches a programmed value. Two auxiliary capture channels latch the count on a rising edge of their trigger pins. An event register collects these flags, clears each one when software writes a 1 to it, and drives a single interrupt line through per-event mask bits. Software reaches everything through a plain single-cycle register port. A write takes effect at the clock edge where `reg_wr` is high. A read that is strobed with `reg_rd` returns its data on `reg_rdata` after that edge, and the data then holds until the next read. The port has no handshake, so it never applies back-pressure.

Top module: `trimmed_ptp_clock`

## Requirements
- R1: After `rst_n` the word register map reads as follows: address 0 control = 0, address 1 events = 0, address 2 rate word = 0xA0000000. `irq` is low.
- R2: The rate word (address 2) is added into a 32-bit accumulator every cycle, and each carry increments the count. After a soft reset releases with rate word A, M cycles later the count equals floor(M*A/2^32).
- R3: A write to the time low word (address 3) only stages the value and does not change the count. A write to the time high word (address 4) loads {high, staged low} into the count in one cycle, and counting resumes from the loaded value.
- R4: A read of the time low word returns the low half and latches the high half. The next read of the time high word (address 4) returns that latched half, even if the count carried into its high half in between.
- R5: A write to the alarm high word (address 6, after the low word at address 5) arms the comparator. While armed, once the count is greater than or equal to the 64-bit alarm value, event bit 1 is set once and the comparator disarms. Only a new alarm write re-arms it.
- R6: A rising edge on `aux_trig_0` copies the count into the channel 0 capture pair (addresses 7 low, 8 high) and sets event bit 2. A rising edge on `aux_trig_1` does the same into addresses 9 and 10 and sets event bit 3. A trigger held high captures only once.
- R7: A capture that arrives while its event flag is still set overwrites the captured value and leaves the flag set.
- R8: Writing the event register (address 1) clears each bit that is written as 1, and bits written as 0 are not affected. A flag that is set in the same cycle as a clear stays set.
- R9: `irq` is high exactly when an event bit k (1 to 4) is set together with control mask bit k. Control bits 1, 2, 3 and 4 mask the alarm event, the capture 0 event, the capture 1 event and the reserved pulse event, in that order.
- R10: While control bit 0 is 1, the count, the accumulator, all event flags, both capture pairs and the alarm arming are held at zero, and time writes are ignored. The rate word, the alarm value and the masks keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid after the read edge |
| aux_trig_0 | input | 1 | Capture channel 0 trigger |
| aux_trig_1 | input | 1 | Capture channel 1 trigger |
| irq | output | 1 | Masked event interrupt |

## Verification
The rate test uses many random rate words and interval lengths and compares the count against the closed-form carry count. An off-by-one in when the accumulator starts after a soft reset, or a lost carry, would shift that result. The coherent-read sequence makes the low half roll over between the low and high reads. A design that reads the high half live would then return a value one too large. The alarm is reached by jumping past the target and across the word boundary, so an equality compare would never fire, and a design that does not disarm would fire again after the flag is cleared. The bench also clears a capture flag in the same cycle that a capture sets it, where a clear-wins design would lose the event, and it holds a trigger high while the count changes, where a level-sensitive capture would overwrite the stored value.

// File: rtl/tptc_pkg.sv
package tptc_pkg;
  localparam int ADDR_W  = 4;
  localparam int NUM_EV  = 4;
  localparam int CTRL_W  = NUM_EV + 1;
  localparam int NUM_AUX = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL    = 4'd0,
    RA_EVENT   = 4'd1,
    RA_RATE    = 4'd2,
    RA_TIME_LO = 4'd3,
    RA_TIME_HI = 4'd4,
    RA_ALM_LO  = 4'd5,
    RA_ALM_HI  = 4'd6,
    RA_AUX0_LO = 4'd7,
    RA_AUX0_HI = 4'd8,
    RA_AUX1_LO = 4'd9,
    RA_AUX1_HI = 4'd10
  } reg_addr_e;

  // index into the internal event vector (register bit = index + 1)
  localparam int EV_ALARM = 0;
  localparam int EV_AUX0  = 1;
  localparam int EV_AUX1  = 2;
  localparam int EV_PULSE = 3;
endpackage

// File: rtl/tptc_time_core.sv
module tptc_time_core #(
  parameter int TIME_W = 64,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [ACC_W-1:0]  rate,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  output logic [TIME_W-1:0] time_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, rate};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      time_o <= '0;
    end else if (hold) begin
      acc_q  <= '0;
      time_o <= '0;
    end else begin
      acc_q <= sum[ACC_W-1:0];
      if (load)
        time_o <= load_val;
      else if (sum[ACC_W])
        time_o <= time_o + TIME_W'(1);
    end
  end
endmodule

// File: rtl/tptc_alarm.sv
module tptc_alarm #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              arm,
  input  logic [TIME_W-1:0] time_i,
  input  logic [TIME_W-1:0] target_i,
  output logic              hit_o
);
  logic armed_q;
  logic reached;

  assign reached = time_i >= target_i;
  assign hit_o   = armed_q && reached && !arm && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (hold)   armed_q <= 1'b0;
    else if (arm)    armed_q <= 1'b1;
    else if (hit_o)  armed_q <= 1'b0;
  end
endmodule

// File: rtl/tptc_aux_capture.sv
module tptc_aux_capture #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              trig,
  input  logic [TIME_W-1:0] time_i,
  output logic [TIME_W-1:0] snap_o,
  output logic              capture_o
);
  logic trig_q;

  assign capture_o = trig && !trig_q && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      snap_o <= '0;
    end else begin
      trig_q <= trig;
      if (hold)
        snap_o <= '0;
      else if (capture_o)
        snap_o <= time_i;
    end
  end
endmodule

// File: rtl/tptc_event_bank.sv
module tptc_event_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] ev_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ev_o <= '0;
    else if (hold) ev_o <= '0;
    else           ev_o <= (ev_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/trimmed_ptp_clock.sv
module trimmed_ptp_clock
  import tptc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RATE_RST = 32'hA000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              aux_trig_0,
  input  logic              aux_trig_1,
  output logic              irq
);
  localparam int TIME_W = 2 * DATA_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] rate_q;
  logic [DATA_W-1:0] lo_stage_q;
  logic [DATA_W-1:0] hi_latch_q;
  logic [TIME_W-1:0] alm_q;
  logic [TIME_W-1:0] time_q;
  logic [NUM_EV-1:0] ev_q;
  logic [NUM_EV-1:0] ev_set;
  logic [NUM_EV-1:0] ev_clr;
  logic [DATA_W-1:0] rd_mux;
  logic              soft_rst;
  logic              time_load;
  logic              alm_arm;
  logic              alm_hit;
  logic [NUM_AUX-1:0] aux_trig;
  logic [NUM_AUX-1:0] aux_cap;
  logic [TIME_W-1:0] aux_snap [NUM_AUX];

  assign soft_rst  = ctrl_q[0];
  assign time_load = reg_wr && (reg_addr == RA_TIME_HI);
  assign alm_arm   = reg_wr && (reg_addr == RA_ALM_HI);
  assign ev_clr    = (reg_wr && (reg_addr == RA_EVENT)) ? reg_wdata[NUM_EV:1] : '0;
  assign aux_trig  = {aux_trig_1, aux_trig_0};

  // software-visible configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      rate_q     <= RATE_RST;
      lo_stage_q <= '0;
      alm_q      <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_CTRL:    ctrl_q                   <= reg_wdata[CTRL_W-1:0];
        RA_RATE:    rate_q                   <= reg_wdata;
        RA_TIME_LO: lo_stage_q               <= reg_wdata;
        RA_ALM_LO:  alm_q[DATA_W-1:0]        <= reg_wdata;
        RA_ALM_HI:  alm_q[TIME_W-1:DATA_W]   <= reg_wdata;
        default: ;
      endcase
    end
  end

  tptc_time_core #(.TIME_W(TIME_W), .ACC_W(DATA_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (soft_rst),
    .rate     (rate_q),
    .load     (time_load),
    .load_val ({reg_wdata, lo_stage_q}),
    .time_o   (time_q)
  );

  tptc_alarm #(.TIME_W(TIME_W)) u_alarm (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (soft_rst),
    .arm      (alm_arm),
    .time_i   (time_q),
    .target_i (alm_q),
    .hit_o    (alm_hit)
  );

  for (genvar g = 0; g < NUM_AUX; g++) begin : g_aux
    tptc_aux_capture #(.TIME_W(TIME_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (soft_rst),
      .trig      (aux_trig[g]),
      .time_i    (time_q),
      .snap_o    (aux_snap[g]),
      .capture_o (aux_cap[g])
    );
  end

  always_comb begin
    ev_set           = '0;
    ev_set[EV_ALARM] = alm_hit;
    ev_set[EV_AUX0]  = aux_cap[0];
    ev_set[EV_AUX1]  = aux_cap[1];
    ev_set[EV_PULSE] = 1'b0;
  end

  tptc_event_bank #(.N(NUM_EV)) u_events (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (soft_rst),
    .set_i (ev_set),
    .clr_i (ev_clr),
    .ev_o  (ev_q)
  );

  assign irq = |(ev_q & ctrl_q[NUM_EV:1]);

  always_comb begin
    case (reg_addr)
      RA_CTRL:    rd_mux = DATA_W'(ctrl_q);
      RA_EVENT:   rd_mux = DATA_W'({ev_q, 1'b0});
      RA_RATE:    rd_mux = rate_q;
      RA_TIME_LO: rd_mux = time_q[DATA_W-1:0];
      RA_TIME_HI: rd_mux = hi_latch_q;
      RA_ALM_LO:  rd_mux = alm_q[DATA_W-1:0];
      RA_ALM_HI:  rd_mux = alm_q[TIME_W-1:DATA_W];
      RA_AUX0_LO: rd_mux = aux_snap[0][DATA_W-1:0];
      RA_AUX0_HI: rd_mux = aux_snap[0][TIME_W-1:DATA_W];
      RA_AUX1_LO: rd_mux = aux_snap[1][DATA_W-1:0];
      RA_AUX1_HI: rd_mux = aux_snap[1][TIME_W-1:DATA_W];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      hi_latch_q <= '0;
    end else begin
      if (reg_rd)
        reg_rdata <= rd_mux;
      if (soft_rst)
        hi_latch_q <= '0;
      else if (reg_rd && (reg_addr == RA_TIME_LO))
        hi_latch_q <= time_q[TIME_W-1:DATA_W];
    end
  end
endmodule

// File: rtl/trimmed_ptp_clock_chk.sv
module trimmed_ptp_clock_chk #(
  parameter int TIME_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [3:0]        reg_addr,
  input logic              aux_trig_0,
  input logic              irq,
  input logic [4:0]        ctrl_i,
  input logic [3:0]        ev_i,
  input logic [TIME_W-1:0] time_i,
  input logic [TIME_W-1:0] alm_i
);
  // R2
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i[0] && !(reg_wr && reg_addr == 4'd4)) |=>
      (time_i == $past(time_i)) || (time_i == $past(time_i) + TIME_W'(1)));

  // R10
  soft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_i[0] |=> (time_i == '0) && (ev_i == '0));

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i[4:1] == 4'd0) |-> !irq);

  // R6
  aux_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(aux_trig_0) && !ctrl_i[0]) |=> ev_i[1]);

  // R7
  aux_keep_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i[1] && $rose(aux_trig_0) && !ctrl_i[0]) |=> ev_i[1]);

  // R5
  alarm_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_i[0]) |-> $past(time_i >= alm_i));
endmodule

bind trimmed_ptp_clock trimmed_ptp_clock_chk #(.TIME_W(TIME_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .aux_trig_0 (aux_trig_0),
  .irq        (irq),
  .ctrl_i     (ctrl_q),
  .ev_i       (ev_q),
  .time_i     (time_q),
  .alm_i      (alm_q)
);

// File: tb/test_trimmed_ptp_clock.sv
module test_trimmed_ptp_clock;
  import tptc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        aux_trig_0 = 1'b0;
  logic        aux_trig_1 = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trimmed_ptp_clock i_trimmed_ptp_clock (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .aux_trig_0(aux_trig_0), .aux_trig_1(aux_trig_1), .irq(irq)
  );

  function automatic logic [63:0] exp_ticks(input int unsigned m, input logic [31:0] a);
    return (64'(m) * 64'(a)) >> 32;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start right after a falling edge and end right after one
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, 64'(d), 64'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_time(input logic [31:0] hi, input logic [31:0] lo);
    wr(RA_TIME_LO, lo);
    wr(RA_TIME_HI, hi);
  endtask

  task automatic pulse(input int ch);
    if (ch == 0) aux_trig_0 = 1'b1; else aux_trig_1 = 1'b1;
    @(negedge clk);
    aux_trig_0 = 1'b0; aux_trig_1 = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d, a, hi, lo;
    int unsigned k;
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rdchk("R1 ctrl", RA_CTRL, 32'h0);
    rdchk("R1 events", RA_EVENT, 32'h0);
    rdchk("R1 rate", RA_RATE, 32'hA000_0000);
    chk("R1 irq", 64'(irq), 64'h0);

    // R2: nominal rate, then random rates
    wr(RA_CTRL, 32'h1);
    wr(RA_RATE, 32'hA000_0000);
    wr(RA_CTRL, 32'h0);
    idle(8);
    rdchk("R2 nominal lo", RA_TIME_LO, 32'(exp_ticks(8, 32'hA000_0000)));
    rdchk("R2 nominal hi", RA_TIME_HI, 32'h0);
    for (int i = 0; i < 8; i++) begin
      a = $urandom();
      k = 1 + ($urandom() % 300);
      wr(RA_CTRL, 32'h1);
      wr(RA_RATE, a);
      wr(RA_CTRL, 32'h0);
      idle(int'(k));
      rdchk("R2 random rate", RA_TIME_LO, 32'(exp_ticks(k, a)));
    end

    // R3: low write stages only, high write loads both
    wr(RA_CTRL, 32'h1);
    wr(RA_RATE, 32'h0);
    wr(RA_CTRL, 32'h0);
    load_time(32'h0000_0012, 32'h3456_789A);
    rdchk("R3 load lo", RA_TIME_LO, 32'h3456_789A);
    rdchk("R3 load hi", RA_TIME_HI, 32'h0000_0012);
    wr(RA_TIME_LO, 32'h1111_1111);
    idle(2);
    rdchk("R3 staged lo ignored", RA_TIME_LO, 32'h3456_789A);

    // R4: coherent read across a rollover of the low half
    wr(RA_RATE, 32'hFFFF_FFFF);
    load_time(32'h5, 32'hFFFF_FFFD);
    rdchk("R4 lo first", RA_TIME_LO, 32'hFFFF_FFFD);
    rdchk("R4 hi first", RA_TIME_HI, 32'h5);
    rdchk("R4 lo second", RA_TIME_LO, 32'hFFFF_FFFF);
    rdchk("R4 hi latched", RA_TIME_HI, 32'h5);
    rdchk("R4 lo after wrap", RA_TIME_LO, 32'h1);
    rdchk("R4 hi after wrap", RA_TIME_HI, 32'h6);

    // R5: alarm with greater-or-equal and single firing
    wr(RA_RATE, 32'h0);
    load_time(32'h0, 32'd100);
    wr(RA_ALM_LO, 32'd200);
    wr(RA_ALM_HI, 32'h0);
    idle(2);
    rdchk("R5 below target", RA_EVENT, 32'h0);
    load_time(32'h0, 32'd250);
    idle(2);
    rdchk("R5 passed target", RA_EVENT, 32'h2);
    wr(RA_EVENT, 32'h2);
    idle(3);
    rdchk("R5 fires once", RA_EVENT, 32'h0);
    wr(RA_ALM_HI, 32'h0);
    idle(2);
    rdchk("R5 rearm", RA_EVENT, 32'h2);
    wr(RA_EVENT, 32'h2);
    wr(RA_ALM_LO, 32'hFFFF_FFFF);
    wr(RA_ALM_HI, 32'h0);
    idle(2);
    rdchk("R5 word boundary below", RA_EVENT, 32'h0);
    load_time(32'h1, 32'h0);
    idle(2);
    rdchk("R5 word boundary reached", RA_EVENT, 32'h2);

    // R9: interrupt masking
    wr(RA_CTRL, 32'h2);
    chk("R9 irq unmasked", 64'(irq), 64'h1);
    wr(RA_CTRL, 32'h4);
    chk("R9 irq other mask", 64'(irq), 64'h0);
    wr(RA_CTRL, 32'h0);
    chk("R9 irq no mask", 64'(irq), 64'h0);
    wr(RA_EVENT, 32'h1E);

    // R6: capture on rising edge only
    load_time(32'h7, 32'h1234);
    aux_trig_0 = 1'b1;
    @(negedge clk);
    load_time(32'h7, 32'h9999);
    idle(2);
    aux_trig_0 = 1'b0;
    idle(1);
    rdchk("R6 aux0 lo held trigger", RA_AUX0_LO, 32'h1234);
    rdchk("R6 aux0 hi", RA_AUX0_HI, 32'h7);
    rdchk("R6 aux0 flag", RA_EVENT, 32'h4);
    wr(RA_CTRL, 32'h4);
    chk("R9 irq capture", 64'(irq), 64'h1);
    wr(RA_CTRL, 32'h0);

    // R7: capture with flag still set overwrites
    load_time(32'h7, 32'h5678);
    pulse(0);
    idle(1);
    rdchk("R7 aux0 overwrite", RA_AUX0_LO, 32'h5678);
    rdchk("R7 flag kept", RA_EVENT, 32'h4);

    load_time(32'hABCD, 32'h42);
    pulse(1);
    idle(1);
    rdchk("R6 aux1 lo", RA_AUX1_LO, 32'h42);
    rdchk("R6 aux1 hi", RA_AUX1_HI, 32'hABCD);
    rdchk("R6 both flags", RA_EVENT, 32'hC);
    rdchk("R6 aux0 untouched", RA_AUX0_LO, 32'h5678);

    // R8: write-one-to-clear, set wins
    wr(RA_EVENT, 32'h0);
    rdchk("R8 zero write", RA_EVENT, 32'hC);
    wr(RA_EVENT, 32'h4);
    rdchk("R8 clear one", RA_EVENT, 32'h8);
    aux_trig_1 = 1'b1;
    wr(RA_EVENT, 32'h8);
    aux_trig_1 = 1'b0;
    rdchk("R8 set wins", RA_EVENT, 32'h8);
    wr(RA_EVENT, 32'h8);
    rdchk("R8 cleared", RA_EVENT, 32'h0);

    // R6: random captures
    for (int i = 0; i < 6; i++) begin
      hi = $urandom();
      lo = $urandom();
      load_time(hi, lo);
      pulse(1);
      idle(1);
      rdchk("R6 random lo", RA_AUX1_LO, lo);
      rdchk("R6 random hi", RA_AUX1_HI, hi);
    end

    // R10: soft reset holds state
    load_time(32'h3, 32'h3);
    wr(RA_RATE, 32'h1234_5678);
    wr(RA_CTRL, 32'h1);
    idle(4);
    rdchk("R10 time lo", RA_TIME_LO, 32'h0);
    rdchk("R10 time hi", RA_TIME_HI, 32'h0);
    rdchk("R10 events", RA_EVENT, 32'h0);
    rdchk("R10 aux1", RA_AUX1_LO, 32'h0);
    rdchk("R10 rate kept", RA_RATE, 32'h1234_5678);
    rdchk("R10 alarm kept", RA_ALM_LO, 32'hFFFF_FFFF);
    load_time(32'h5, 32'h5);
    idle(3);
    rdchk("R10 load ignored", RA_TIME_LO, 32'h0);
    wr(RA_CTRL, 32'h0);
    idle(20);
    rdchk("R2 after release", RA_TIME_LO, 32'(exp_ticks(20, 32'h1234_5678)));

    finish_run();
  end
endmodule